// File: doc/BRIEF.md
# Rectangle Blit Destination Address Generator

This block produces the stream of back-buffer write addresses for copying a rectangle of pixels into a 400x300 frame. A processor first loads four 9-bit coordinates through an 8-bit register port: a start and an end for X and for Y, each as a low byte and a high byte. It then pulses a run input. From the next cycle on, the block emits one address per clock in raster order and raises a pixel strobe alongside each one. When the rectangle is finished it drops busy and raises done, which the processor polls before it sends the next command.

Each axis holds its start and end values in registers. The X counter counts up from its start. When it reaches the last column it reloads the start value, and that same wrap moves the Y counter on by one line. When Y wraps at its last line, the engine stops. End coordinates are exclusive, so the rectangle spans X1..X2-1 by Y1..Y2-1. While idle, the address output is zero and its output-enable is low, so a shared bus can treat it as undriven.

Top module: `blit_dest_addr_gen`

## Requirements
- R1: After reset, busy, done, addr_oe and pix_valid are all low and addr is zero.
- R2: A write with cfg_we high stores cfg_wdata into the register chosen by cfg_sel: 0 = X start low byte, 1 = X start high, 2 = X end low, 3 = X end high, 4 = Y start low, 5 = Y start high, 6 = Y end low, 7 = Y end high. A high byte supplies coordinate bit 8 from cfg_wdata bit 0.
- R3: While busy is low, addr_oe and pix_valid are low and addr is zero.
- R4: While busy, X starts at the X start value and rises by one each cycle. After the value X end minus one, X returns to the X start value.
- R5: Y starts at the Y start value and rises by one only in the cycle after X returns to its start. Y stays within Y start..Y end-1.
- R6: The cycle after the last pixel (X end-1, Y end-1), busy falls and done rises. Done stays high until the next accepted run.
- R7: A run with X start >= X end or Y start >= Y end emits no pixel. Busy stays low and done is high from the next cycle.
- R8: While busy, register writes and run pulses have no effect on the coordinates in use or on later commands.
- R9: The address is {Y, X}, with Y on bits 17:9 and X on bits 8:0. pix_valid and addr_oe are high for exactly width x height cycles per run.
- R10: A full 400x300 rectangle starting at (0,0) is emitted completely, from address 0 to {299, 399}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Coordinate byte write strobe |
| cfg_sel | input | 3 | Selects which coordinate byte is written |
| cfg_wdata | input | 8 | Coordinate byte value |
| run | input | 1 | Start command, ignored while busy |
| busy | output | 1 | High while a rectangle is being emitted |
| done | output | 1 | High once the last command has completed |
| addr_oe | output | 1 | High when addr carries a valid destination |
| pix_valid | output | 1 | One pulse per emitted pixel address |
| addr | output | 18 | Destination address {Y, X} |

## Verification
The embedded assertions check these on every cycle: both counters stay inside their windows, X steps by one between wraps, the coordinate registers do not change while the engine runs, and done follows the end of each run. The exact raster order, the number of pixel pulses, the handling of empty rectangles, and the proof that writes and run pulses during a run leave later commands unchanged can only be shown by the bench scenarios. Those scenarios compare every emitted address against an independently walked rectangle.

// File: rtl/blit_dest_addr_gen.sv
module blit_dest_addr_gen #(
  parameter int CW = 9,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [BW-1:0] cfg_wdata,
  input  logic          run,
  output logic          busy,
  output logic          done,
  output logic          addr_oe,
  output logic          pix_valid,
  output logic [2*CW-1:0] addr
);
  localparam int HW = CW - BW;

  logic [CW-1:0] x_lo, x_hi, y_lo, y_hi, xc, yc;
  logic x_last, y_last, empty;

  assign x_last    = (xc + CW'(1)) == x_hi;
  assign y_last    = (yc + CW'(1)) == y_hi;
  assign empty     = (x_lo >= x_hi) || (y_lo >= y_hi);
  assign addr_oe   = busy;
  assign pix_valid = busy;
  assign addr      = busy ? {yc, xc} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_lo <= '0; x_hi <= '0; y_lo <= '0; y_hi <= '0;
    end else if (cfg_we && !busy) begin
      case (cfg_sel)
        3'd0: x_lo[BW-1:0]  <= cfg_wdata;
        3'd1: x_lo[CW-1:BW] <= cfg_wdata[HW-1:0];
        3'd2: x_hi[BW-1:0]  <= cfg_wdata;
        3'd3: x_hi[CW-1:BW] <= cfg_wdata[HW-1:0];
        3'd4: y_lo[BW-1:0]  <= cfg_wdata;
        3'd5: y_lo[CW-1:BW] <= cfg_wdata[HW-1:0];
        3'd6: y_hi[BW-1:0]  <= cfg_wdata;
        default: y_hi[CW-1:BW] <= cfg_wdata[HW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; xc <= '0; yc <= '0;
    end else if (!busy) begin
      if (run) begin
        xc   <= x_lo;
        yc   <= y_lo;
        busy <= !empty;
        done <= empty;
      end
    end else if (x_last) begin
      xc <= x_lo;
      if (y_last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        yc <= yc + CW'(1);
      end
    end else begin
      xc <= xc + CW'(1);
    end
  end

  assert_x_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (xc >= x_lo) && (xc < x_hi));
  assert_y_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (yc >= y_lo) && (yc < y_hi));
  assert_x_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !x_last |=> busy && (xc == $past(xc) + CW'(1)));
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({x_lo, x_hi, y_lo, y_hi}));
  assert_done_on_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pix_valid && !addr_oe && (addr == '0));
endmodule

// File: tb/blit_dest_addr_gen_tb.sv
module blit_dest_addr_gen_tb;
  logic clk = 0, rst_n = 0, cfg_we = 0, run = 0;
  logic [2:0] cfg_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic busy, done, addr_oe, pix_valid;
  logic [17:0] addr;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  blit_dest_addr_gen u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .run(run), .busy(busy), .done(done), .addr_oe(addr_oe),
    .pix_valid(pix_valid), .addr(addr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk); cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = 8'(val);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic setup(input int x1, input int x2, input int y1, input int y2);
    wr(0, x1 & 255); wr(1, x1 >> 8); wr(2, x2 & 255); wr(3, x2 >> 8);
    wr(4, y1 & 255); wr(5, y1 >> 8); wr(6, y2 & 255); wr(7, y2 >> 8);
  endtask

  // walk the rectangle independently; optionally poke writes/run while busy
  task automatic blit(input string req, input int x1, input int x2, input int y1, input int y2,
                      input bit poke);
    int w = x2 - x1, h = y2 - y1, k = 0, bad = 0;
    @(negedge clk); run = 1;
    @(negedge clk); run = 0;
    for (int y = y1; y < y2; y++)
      for (int x = x1; x < x2; x++) begin
        if (busy !== 1 || pix_valid !== 1 || addr_oe !== 1 || addr !== {9'(y), 9'(x)}) begin
          bad++;
          if (bad < 4) $display("FAIL %s R4 R5 R9 pixel %0d addr actual=%0h expected=%0h",
                                req, k, addr, {9'(y), 9'(x)});
        end
        if (poke && k == 1) begin cfg_we = 1; cfg_sel = 3'd2; cfg_wdata = 8'd0; run = 1; end
        if (poke && k == 2) begin cfg_we = 0; run = 0; end
        k++;
        @(negedge clk);
      end
    cfg_we = 0; run = 0;
    chk({req, " R9 mismatching pixels"}, bad, 0);
    chk({req, " R9 pixel count"}, k, w * h);
    chk({req, " R6 busy low after last"}, busy, 0);
    chk({req, " R6 done high"}, done, 1);
    chk({req, " R3 oe low idle"}, addr_oe, 0);
    chk({req, " R3 addr zero idle"}, addr, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 oe", addr_oe, 0); chk("R1 valid", pix_valid, 0); chk("R1 addr", addr, 0);
    rst_n = 1;
  endtask

  task automatic t_small;
    setup(50, 53, 60, 62);
    blit("R4 small", 50, 53, 60, 62, 0);
  endtask

  task automatic t_high_bits;
    setup(396, 400, 297, 300);  // R2 high bytes carry bit 8
    blit("R2 high coords", 396, 400, 297, 300, 0);
  endtask

  task automatic t_single;
    setup(7, 8, 9, 10);
    blit("R5 1x1", 7, 8, 9, 10, 0);
  endtask

  task automatic t_empty;
    setup(10, 10, 0, 5);
    @(negedge clk); run = 1;
    @(negedge clk); run = 0;
    chk("R7 empty x busy", busy, 0); chk("R7 empty x done", done, 1);
    chk("R7 empty x valid", pix_valid, 0);
    setup(0, 5, 20, 3);
    @(negedge clk); run = 1;
    @(negedge clk); run = 0;
    chk("R7 empty y busy", busy, 0); chk("R7 empty y done", done, 1);
  endtask

  task automatic t_busy_ignore;
    setup(100, 104, 30, 33);
    blit("R8 during run", 100, 104, 30, 33, 1);
    repeat (2) @(negedge clk);
    chk("R8 no restart", busy, 0);
    blit("R8 config kept", 100, 104, 30, 33, 0);
  endtask

  task automatic t_done_clear;
    setup(0, 2, 0, 2);
    @(negedge clk); run = 1;
    @(negedge clk); run = 0;
    chk("R6 done cleared on run", done, 0);
    repeat (4) @(negedge clk);
    chk("R6 done after", done, 1);
  endtask

  task automatic t_full;
    setup(0, 400, 0, 300);
    blit("R10 full screen", 0, 400, 0, 300, 0);
  endtask

  initial begin
    t_reset();
    t_small();
    t_high_bits();
    t_single();
    t_empty();
    t_busy_ignore();
    t_done_clear();
    t_full();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule